// File: doc/BRIEF.md
# SPI Master Loopback Integrity Exerciser

This block is an SPI master that keeps a link to an echoing slave busy with a known pattern and watches what comes back. Each transfer lowers an active-low select, waits a guard interval, shifts one byte out MSB first while shifting the reply in, raises select again and waits a second guard interval. The byte sent grows by one on every transfer. The slave is expected to return the inverse of the byte it received in the transfer before.

A wrong reply pulls an active-low error line low for a long, visible interval. The clock polarity, the clock phase and the SCK divider are inputs. They are captured when a byte starts, so every one of the four SPI modes and every rate can be exercised against a slave. Guard delays and the error interval are set in nanoseconds and converted to system-clock cycles at elaboration.

Top module: `spi_loop_exerciser`

## Requirements
- R1: While reset is held, `cs_n` is 1, `err_n` is 1 and `sclk` is 0.
- R2: SETUP_CYC = ceil(CLK_HZ·SETUP_NS/1e9). The first SCK edge of a byte comes SETUP_CYC + div/2 system cycles after `cs_n` falls.
- R3: Divider code k (0..6) selects a divider of 2^(k+1), and code 7 selects 128. Code 1 (divide by 4) is the usual setting. A byte has exactly 16 SCK edges, spaced div/2 system cycles apart.
- R4: `cs_n` rises one system cycle after the last SCK edge. It falls again HOLD_CYC = ceil(CLK_HZ·HOLD_NS/1e9) cycles later.
- R5: The first byte sent after reset is 1. Each later byte is the previous one plus 1, modulo 256, and is shifted MSB first.
- R6: With `cpha`=0 (modes 0 and 2), MOSI holds bit 7 before the first edge. MOSI changes on trailing edges, and MISO is sampled on leading edges.
- R7: With `cpha`=1 (modes 1 and 3), MOSI changes on leading edges, and MISO is sampled on trailing edges.
- R8: A reply other than ~(sent byte − 1) drives `err_n` low from the edge on which `cs_n` rises, for ERR_CYC = ceil(CLK_HZ·ERR_NS/1e9) cycles. A further mismatch while `err_n` is low restarts that interval.
- R9: The reply to the first transfer after reset is never flagged.
- R10: While deselected, `sclk` equals the value `cpol` had one cycle earlier. `cpol`, `cpha` and `div_code` are captured when the engine starts. `sclk` and `cs_n` never change on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| div_code | input | 3 | SCK divider code (R3) |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low slave select |
| err_n | output | 1 | Active-low stretched mismatch flag |

## Verification
Every timing result is measured in system cycles from the `cs_n` or SCK transition that causes it:
- the first SCK edge is due SETUP_CYC + div/2 cycles after select falls;
- later edges are due div/2 cycles apart;
- select rises one cycle after the sixteenth edge;
- select falls again HOLD_CYC cycles after that;
- `err_n` falls on the very cycle select rises and recovers ERR_CYC cycles after its latest trigger.

The bench samples on the falling clock edge. It stamps each transition with a cycle counter and compares the differences with these counts. Its echoing slave model reacts to SCK edges in the mode under test, so the byte it receives checks the master's shifting. The `err_n` behaviour checks the master's sampling.

// File: rtl/spi_lx_pkg.sv
package spi_lx_pkg;

    localparam int DIV_CODE_W = 3;
    localparam int HALF_W     = 7;

    typedef enum logic [1:0] {
        SQ_HOLD  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_XFER  = 2'd2
    } seq_state_e;

    // Half SCK period in system cycles for a divider code.
    function automatic logic [HALF_W-1:0] half_of(input logic [DIV_CODE_W-1:0] code);
        logic [HALF_W-1:0] h;
        if (code == 3'd7) begin
            h = 7'd64;
        end else begin
            h = 7'd1 << code;
        end
        return h;
    endfunction

endpackage

// File: rtl/lx_shift_engine.sv
module lx_shift_engine
    import spi_lx_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  cpol,
    input  logic                  cpha,
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic [BITS-1:0]       tx_byte,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  done,
    output logic [BITS-1:0]       rx_byte
);

    localparam int NEDGE = 2 * BITS;
    localparam int EW    = $clog2(NEDGE);
    localparam logic [EW-1:0] LAST_EDGE = EW'(NEDGE - 1);

    typedef struct packed {
        logic              busy;
        logic              cpha;
        logic [HALF_W-1:0] half;
        logic [HALF_W-1:0] hcnt;
        logic [EW-1:0]     edge_idx;
        logic              sclk;
        logic [BITS-1:0]   tx_sr;
        logic [BITS-1:0]   rx_sr;
        logic              done;
    } eng_t;

    eng_t eng_d, eng_q;
    logic lead;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        lead       = ~eng_q.edge_idx[0];
        if (!eng_q.busy) begin
            eng_d.sclk = cpol;
            if (start) begin
                eng_d.busy     = 1'b1;
                eng_d.cpha     = cpha;
                eng_d.half     = half_of(div_code);
                eng_d.hcnt     = '0;
                eng_d.edge_idx = '0;
                eng_d.tx_sr    = tx_byte;
            end
        end else if (eng_q.hcnt == eng_q.half - 7'd1) begin
            eng_d.hcnt     = '0;
            eng_d.sclk     = ~eng_q.sclk;
            eng_d.edge_idx = eng_q.edge_idx + 1'b1;
            if (lead ^ eng_q.cpha) begin
                eng_d.rx_sr = {eng_q.rx_sr[BITS-2:0], miso};
            end else if (eng_q.edge_idx != '0 && eng_q.edge_idx != LAST_EDGE) begin
                eng_d.tx_sr = {eng_q.tx_sr[BITS-2:0], 1'b0};
            end
            if (eng_q.edge_idx == LAST_EDGE) begin
                eng_d.busy = 1'b0;
                eng_d.done = 1'b1;
            end
        end else begin
            eng_d.hcnt = eng_q.hcnt + 7'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sclk    = eng_q.sclk;
    assign mosi    = eng_q.tx_sr[BITS-1];
    assign done    = eng_q.done;
    assign rx_byte = eng_q.rx_sr;

endmodule

// File: rtl/lx_err_stretch.sv
module lx_err_stretch #(
    parameter int LEN = 100,
    parameter int CW  = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic err_n
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          err_n;
    } str_t;

    str_t str_d, str_q;

    always_comb begin
        str_d = str_q;
        if (trig) begin
            str_d.cnt = CW'(LEN);
        end else if (str_q.cnt != '0) begin
            str_d.cnt = str_q.cnt - 1'b1;
        end
        str_d.err_n = (str_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            str_q <= '{cnt: '0, err_n: 1'b1};
        end else begin
            str_q <= str_d;
        end
    end

    assign err_n = str_q.err_n;

endmodule

// File: rtl/spi_loop_exerciser.sv
module spi_loop_exerciser
    import spi_lx_pkg::*;
#(
    parameter int CLK_HZ   = 250_000_000,
    parameter int SETUP_NS = 1500,
    parameter int HOLD_NS  = 1000,
    parameter int ERR_NS   = 100_000_000,
    parameter int BITS     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpol,
    input  logic                  cpha,
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  cs_n,
    output logic                  err_n
);

    localparam longint NS_PER_S = 64'd1_000_000_000;
    localparam longint SETUP_L  = (longint'(CLK_HZ) * SETUP_NS + NS_PER_S - 1) / NS_PER_S;
    localparam longint HOLD_L   = (longint'(CLK_HZ) * HOLD_NS + NS_PER_S - 1) / NS_PER_S;
    localparam longint ERR_L    = (longint'(CLK_HZ) * ERR_NS + NS_PER_S - 1) / NS_PER_S;
    localparam int SETUP_CYC = (SETUP_L < 1) ? 1 : int'(SETUP_L);
    localparam int HOLD_CYC  = (HOLD_L < 1) ? 1 : int'(HOLD_L);
    localparam int ERR_CYC   = (ERR_L < 2) ? 2 : int'(ERR_L);
    localparam int GUARD_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int GW        = $clog2(GUARD_MAX + 1);

    typedef struct packed {
        seq_state_e      st;
        logic [GW-1:0]   cnt;
        logic            cs_n;
        logic [BITS-1:0] tx;
        logic            first;
    } seq_t;

    seq_t seq_d, seq_q;
    logic            start;
    logic            err_trig;
    logic            eng_done;
    logic [BITS-1:0] eng_rx;

    always_comb begin
        seq_d    = seq_q;
        start    = 1'b0;
        err_trig = 1'b0;
        unique case (seq_q.st)
            SQ_HOLD: begin
                if (seq_q.cnt == GW'(HOLD_CYC - 1)) begin
                    seq_d.st   = SQ_SETUP;
                    seq_d.cnt  = '0;
                    seq_d.cs_n = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SQ_SETUP: begin
                if (seq_q.cnt == GW'(SETUP_CYC - 1)) begin
                    seq_d.st = SQ_XFER;
                    start    = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SQ_XFER: begin
                if (eng_done) begin
                    seq_d.st    = SQ_HOLD;
                    seq_d.cnt   = '0;
                    seq_d.cs_n  = 1'b1;
                    seq_d.tx    = seq_q.tx + 1'b1;
                    seq_d.first = 1'b0;
                    err_trig    = !seq_q.first &&
                                  (eng_rx != ~(seq_q.tx - BITS'(1)));
                end
            end
            default: seq_d.st = SQ_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_HOLD, cnt: '0, cs_n: 1'b1, tx: BITS'(1), first: 1'b1};
        end else begin
            seq_q <= seq_d;
        end
    end

    lx_shift_engine #(.BITS(BITS)) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cpol     (cpol),
        .cpha     (cpha),
        .div_code (div_code),
        .tx_byte  (seq_q.tx),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .done     (eng_done),
        .rx_byte  (eng_rx)
    );

    lx_err_stretch #(.LEN(ERR_CYC)) i_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (err_trig),
        .err_n (err_n)
    );

    assign cs_n = seq_q.cs_n;

endmodule

// File: rtl/spi_loop_exerciser_chk.sv
module spi_loop_exerciser_chk (
    input logic clk,
    input logic rst_n,
    input logic cpol,
    input logic sclk,
    input logic cs_n,
    input logic err_n
);

    // R10
    idle_sclk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (sclk == $past(cpol)));

    // R10
    sel_clk_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> $stable(sclk));

    // R8
    err_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |-> $rose(cs_n));

    // R8
    err_stretched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);

endmodule

bind spi_loop_exerciser spi_loop_exerciser_chk i_chk (.*);

// File: tb/test_spi_loop_exerciser.sv
module test_spi_loop_exerciser;

    localparam int S_CYC = 10;   // 40 ns at 250 MHz
    localparam int H_CYC = 5;    // 20 ns
    localparam int E_CYC = 100;  // 400 ns

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cpol = 1'b0;
    logic cfg_cpha = 1'b0;
    logic [2:0] cfg_div = 3'd1;
    logic miso = 1'b0;
    logic sclk, mosi, cs_n, err_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spi_loop_exerciser #(
        .CLK_HZ(250_000_000), .SETUP_NS(40), .HOLD_NS(20), .ERR_NS(400), .BITS(8)
    ) i_spi_loop_exerciser (
        .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .cpha(cfg_cpha),
        .div_code(cfg_div), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .err_n(err_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Echoing slave: replies with the inverse of the previous byte it received.
    logic [7:0] s_reply, s_rx, s_last;
    logic [7:0] s_prev = 8'h3C;
    logic s_cs_q = 1'b1;
    logic s_sclk_q = 1'b0;
    logic s_corrupt = 1'b0;
    logic corrupt_req = 1'b0;
    int s_idx = 0;

    always @(sclk, cs_n) begin
        if (cs_n === 1'b0 && s_cs_q !== 1'b0) begin
            s_reply   = ~s_prev ^ (corrupt_req ? 8'h10 : 8'h00);
            s_corrupt = corrupt_req;
            s_rx      = 8'h00;
            if (!cfg_cpha) begin
                miso  = s_reply[7];
                s_idx = 6;
            end else begin
                s_idx = 7;
            end
        end else if (cs_n === 1'b1 && s_cs_q === 1'b0) begin
            s_prev = s_rx;
            s_last = s_rx;
            miso   = 1'b0;
        end else if (cs_n === 1'b0 && sclk !== s_sclk_q) begin
            if ((sclk !== cfg_cpol) ^ cfg_cpha) begin
                s_rx = {s_rx[6:0], mosi};
            end else if (s_idx >= 0) begin
                miso = s_reply[s_idx];
                s_idx--;
            end
        end
        s_cs_q   = cs_n;
        s_sclk_q = sclk;
    end

    // Cycle-stamped monitor, sampled on the falling clock edge.
    int cyc = 0;
    int t_fall = 0, t_edge = 0, t_rise = 0, t_errf = 0;
    int nedge = 0, xfer_no = 0;
    bit have_rise = 1'b0;
    logic [7:0] exp_tx = 8'd1;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_err = 1'b1;

    function automatic int half_cyc(input logic [2:0] code);
        return (code == 3'd7) ? 64 : (1 << code);
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            if (p_cs && !cs_n) begin
                t_fall = cyc;
                nedge  = 0;
                if (have_rise) chk(cyc - t_rise == H_CYC, "R4 hold gap", cyc - t_rise, H_CYC);
            end
            if (sclk !== p_sclk && !cs_n) begin
                nedge++;
                if (nedge == 1)
                    chk(cyc - t_fall == S_CYC + half_cyc(cfg_div), "R2 select to first edge",
                        cyc - t_fall, S_CYC + half_cyc(cfg_div));
                else
                    chk(cyc - t_edge == half_cyc(cfg_div), "R3 edge spacing",
                        cyc - t_edge, half_cyc(cfg_div));
                t_edge = cyc;
            end
            if (!p_cs && cs_n) begin
                t_rise = cyc;
                have_rise = 1'b1;
                chk(nedge == 16, "R3 edge count", nedge, 16);
                chk(cyc - t_edge == 1, "R4 deselect after last edge", cyc - t_edge, 1);
                chk(s_last == exp_tx, cfg_cpha ? "R5 R7 byte seen by slave" : "R5 R6 byte seen by slave",
                    int'(s_last), int'(exp_tx));
                if (xfer_no == 0) begin
                    chk(err_n == 1'b1, "R9 first reply masked", int'(err_n), 1);
                end else if (s_corrupt) begin
                    chk(err_n == 1'b0, "R8 error flagged", int'(err_n), 0);
                end else if (p_err) begin
                    chk(err_n == 1'b1, cfg_cpha ? "R7 reply sampled" : "R6 reply sampled", int'(err_n), 1);
                end
                if (!err_n && (s_corrupt || p_err)) t_errf = cyc;
                exp_tx = exp_tx + 8'd1;
                xfer_no++;
            end
            if (p_err && !err_n) chk(cyc == t_rise, "R8 error starts at deselect", cyc, t_rise);
            if (!p_err && err_n) chk(cyc - t_errf == E_CYC, "R8 error length", cyc - t_errf, E_CYC);
            p_cs   = cs_n;
            p_sclk = sclk;
            p_err  = err_n;
        end
    end

    task automatic run_xfers(input int n);
        for (int i = 0; i < n; i++) @(posedge cs_n);
        #1;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset select", int'(cs_n), 1);
        chk(err_n == 1'b1, "R1 reset error", int'(err_n), 1);
        chk(sclk == 1'b0, "R1 reset clock", int'(sclk), 0);
        rst_n = 1'b1;
        // Long run at the fastest rate, covering the 8-bit wrap (R5).
        cfg_div = 3'd0;
        run_xfers(300);
        // Sweep every mode and every divider code (R3, R6, R7, R10).
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                cfg_cpol = m[1];
                cfg_cpha = m[0];
                cfg_div  = 3'(c);
                run_xfers(3);
                @(negedge clk);
                chk(sclk == cfg_cpol, "R10 idle level", int'(sclk), int'(cfg_cpol));
            end
        end
        // Injected mismatches (R8).
        cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 3'd1;
        run_xfers(2);
        corrupt_req = 1'b1;
        @(negedge cs_n); #1 corrupt_req = 1'b0;
        run_xfers(7);
        corrupt_req = 1'b1;
        @(negedge cs_n); #1;
        @(negedge cs_n); #1 corrupt_req = 1'b0;
        run_xfers(7);
        cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_div = 3'd0;
        run_xfers(1);
        corrupt_req = 1'b1;
        @(negedge cs_n); #1 corrupt_req = 1'b0;
        run_xfers(8);
        finish_run();
    end

endmodule